// File: doc/BRIEF.md
# UART Receiver with Receive FIFO and RTS Flow Control

This block turns an asynchronous serial line into bytes. It oversamples the line at sixteen times the bit rate, using a one-cycle enable supplied from outside, and accepts a start bit only if the line is still low at the middle of that bit. It then collects eight data bits, least significant bit first. An optional parity bit follows, and then one stop bit. Bytes that pass the acceptance rules go into a sixteen-entry FIFO, which software drains through a pop strobe.

Sticky status flags record five events: a byte arriving, a bad stop bit, a parity mismatch, a break, and a byte lost to overrun. A flag can only be cleared if it was seen set by an earlier status read. Three interrupt lines are derived from the flags: receive data, receive error, and break/overrun. The RTS output tells the far transmitter to pause once the FIFO fill reaches a programmable level. RTS is held inactive (high) while the receiver is disabled.

Top module: `uart_rx_fc`

## Requirements
- R1: A frame consists of a start bit (0), 8 data bits sent LSB first, an optional parity bit and one stop bit (1). Each accepted byte is appended to the FIFO. `count_o` rises by one, `rdata_o` shows the oldest byte, and `status_o[0]` (data-ready) sets.
- R2: A low pulse that ends before the middle of the start bit, counted as 8 oversampling ticks, is not taken as a start. No byte is stored.
- R3: With `par_en_i`=1, the parity bit is compared with the XOR of the data bits, inverted when `par_odd_i`=1. A mismatch sets `status_o[2]`, and the byte is still stored.
- R4: A stop bit of 0 on a frame with nonzero data sets `status_o[1]` and still stores the byte. The next frame is received normally once the line has returned high.
- R5: A frame with all-zero data and a zero stop bit is a break. It sets `status_o[3]` (and `status_o[1]`) and is not stored. While `status_o[3]` or `status_o[4]` is set, no byte is stored.
- R6: A byte that completes while the FIFO holds 16 entries sets `status_o[4]` and is dropped. The stored entries are unchanged.
- R7: `pop_i` removes the oldest entry, so bytes leave in arrival order. A pop on an empty FIFO has no effect.
- R8: `irq_rx_o` = `rx_ie_i` AND (data-ready OR `status_o[5]`). `status_o[5]` is 1 when `count_o` is at least the level picked by `fill_sel_i`: code 0 gives 1, code 1 gives 4, code 2 gives 8, code 3 gives 14.
- R9: `irq_err_o` = (`rx_ie_i` OR `err_ie_i`) AND (`status_o[1]` OR `status_o[2]`). `irq_brk_o` = (`rx_ie_i` OR `err_ie_i`) AND (`status_o[3]` OR `status_o[4]`).
- R10: With `rx_en_i`=1, `rts_o` is 0 when `flow_en_i`=0. When `flow_en_i`=1, `rts_o` is 1 exactly when `count_o` is at least the level set by `rts_sel_i`: code 0 gives 15, code 1 gives 1, and codes 2 to 7 give twice the code.
- R11: With `rx_en_i`=0, `rts_o` is 1 and line activity stores nothing.
- R12: `clr_i` clears the flags selected by `clr_mask_i` (bit n clears `status_o[n]`, n = 0 to 4), but only those that were 1 at the last `sts_rd_i` pulse. A flag set after that read stays set.
- R13: The receiver advances only on `baud_tick_i`. With the tick arriving every fourth clock, a frame with a correspondingly longer bit time is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial receive line |
| baud_tick_i | input | 1 | Oversampling enable, 16 per bit |
| rx_en_i | input | 1 | Receiver enable |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1 |
| flow_en_i | input | 1 | RTS flow control enable |
| rts_sel_i | input | 3 | RTS fill level code |
| fill_sel_i | input | 2 | Fill flag level code |
| rx_ie_i | input | 1 | Receive interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| pop_i | input | 1 | Remove oldest FIFO entry |
| rdata_o | output | 8 | Oldest FIFO entry |
| count_o | output | 5 | FIFO fill count |
| sts_rd_i | input | 1 | Status read strobe (arms clears) |
| clr_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 5 | Flags to clear |
| status_o | output | 6 | {fill, overrun, break, parity, framing, data-ready} |
| rts_o | output | 1 | Request-to-send, 1 = stop sending |
| irq_rx_o | output | 1 | Receive data interrupt |
| irq_err_o | output | 1 | Receive error interrupt |
| irq_brk_o | output | 1 | Break/overrun interrupt |

## Verification
A frame's byte, count and flags are decided at the tick that samples the middle of the stop bit. After that they pass through one register: the frame result, then the FIFO and flags one cycle later. All of this happens about half a bit before the line's stop bit ends. Each frame task therefore holds the stop bit for its full length and idles one more bit time before any check, so the results are settled well before sampling. Pops, status reads and clears act at the next clock edge, and `rts_o`, `status_o[5]` and the interrupts follow combinationally. Those values are checked at the falling edge after the strobe is released.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int unsigned FL_DR  = 0;
  localparam int unsigned FL_FER = 1;
  localparam int unsigned FL_PER = 2;
  localparam int unsigned FL_BRK = 3;
  localparam int unsigned FL_OVR = 4;
  localparam int unsigned FL_N   = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       fer;
    logic       per;
    logic       brk;
  } rx_frame_t;

  // RTS level: code 0 -> 15, code 1 -> 1, others -> 2*code
  function automatic int rts_level(input logic [2:0] sel);
    if (sel == 3'd0)      return 15;
    else if (sel == 3'd1) return 1;
    else                  return 2 * int'(sel);
  endfunction

  // fill flag level: 1, 4, 8, 14
  function automatic int fill_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_deframe.sv
module uart_rx_deframe
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      tick,
  input  logic      rxd,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      frm_valid,
  output rx_frame_t frm
);

  localparam int DW  = 8;
  localparam int OSW = $clog2(OSR);
  localparam int BW  = $clog2(DW);
  localparam logic [OSW-1:0] OS_LAST = OSW'(OSR - 1);
  localparam logic [OSW-1:0] OS_HALF = OSW'(OSR / 2 - 1);
  localparam logic [BW-1:0]  BIT_LAST = BW'(DW - 1);

  logic [1:0]     sync_q;
  logic           rx_s;
  rx_state_e      st_q, st_n;
  logic [OSW-1:0] os_q, os_n;
  logic [BW-1:0]  bit_q, bit_n;
  logic [DW-1:0]  sh_q, sh_n;
  logic           par_q, par_n;
  logic           armed_q, armed_n;
  logic           valid_q, valid_n;
  rx_frame_t      frm_q, frm_n;

  assign rx_s = sync_q[1];

  always_comb begin
    st_n    = st_q;
    os_n    = os_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    par_n   = par_q;
    armed_n = armed_q;
    valid_n = 1'b0;
    frm_n   = frm_q;
    if (!en) begin
      st_n    = S_IDLE;
      armed_n = 1'b0;
    end else if (tick) begin
      case (st_q)
        S_IDLE: begin
          if (rx_s) begin
            armed_n = 1'b1;
          end else if (armed_q) begin
            st_n = S_START;
            os_n = '0;
          end
        end
        S_START: begin
          if (os_q == OS_HALF) begin
            os_n  = '0;
            bit_n = '0;
            st_n  = rx_s ? S_IDLE : S_DATA;
          end else begin
            os_n = os_q + 1'b1;
          end
        end
        S_DATA: begin
          if (os_q == OS_LAST) begin
            os_n = '0;
            sh_n = {rx_s, sh_q[DW-1:1]};
            if (bit_q == BIT_LAST) st_n = par_en ? S_PAR : S_STOP;
            else                   bit_n = bit_q + 1'b1;
          end else begin
            os_n = os_q + 1'b1;
          end
        end
        S_PAR: begin
          if (os_q == OS_LAST) begin
            os_n  = '0;
            par_n = rx_s;
            st_n  = S_STOP;
          end else begin
            os_n = os_q + 1'b1;
          end
        end
        S_STOP: begin
          if (os_q == OS_LAST) begin
            valid_n    = 1'b1;
            frm_n.data = sh_q;
            frm_n.fer  = ~rx_s;
            frm_n.per  = par_en && (par_q != ((^sh_q) ^ par_odd));
            frm_n.brk  = (sh_q == '0) && !rx_s;
            st_n       = S_IDLE;
            armed_n    = 1'b0;
          end else begin
            os_n = os_q + 1'b1;
          end
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      st_q    <= S_IDLE;
      os_q    <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      armed_q <= 1'b0;
      valid_q <= 1'b0;
      frm_q   <= '0;
    end else begin
      sync_q  <= {sync_q[0], rxd};
      st_q    <= st_n;
      os_q    <= os_n;
      bit_q   <= bit_n;
      sh_q    <= sh_n;
      par_q   <= par_n;
      armed_q <= armed_n;
      valid_q <= valid_n;
      frm_q   <= frm_n;
    end
  end

  assign frm_valid = valid_q;
  assign frm       = frm_q;

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          push_e, pop_e;

  assign full   = (cnt_q == CNT_FULL);
  assign push_e = push && !full;
  assign pop_e  = pop && (cnt_q != '0);

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (push_e) wp_n = (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
    if (pop_e)  rp_n = (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
    case ({push_e, pop_e})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_e) mem_q[wp_q] <= wdata;
  end

  assign rdata = mem_q[rp_q];
  assign count = cnt_q;

endmodule

// File: rtl/uart_rx_ctl.sv
module uart_rx_ctl
  import uart_rx_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic             frm_fer,
  input  logic             frm_per,
  input  logic             frm_brk,
  input  logic [CNT_W-1:0] count,
  input  logic             full,
  input  logic             rx_en,
  input  logic             flow_en,
  input  logic [2:0]       rts_sel,
  input  logic [1:0]       fill_sel,
  input  logic             rx_ie,
  input  logic             err_ie,
  input  logic             sts_rd,
  input  logic             clr,
  input  logic [FL_N-1:0]  clr_mask,
  output logic             push,
  output logic [FL_N-1:0]  flags,
  output logic             fill,
  output logic             rts,
  output logic             irq_rx,
  output logic             irq_err,
  output logic             irq_brk
);

  logic [FL_N-1:0] flg_q, flg_n;
  logic [FL_N-1:0] arm_q, arm_n;
  logic [FL_N-1:0] set_v, clr_v;
  logic            blocked, accept;

  assign blocked = flg_q[FL_BRK] || flg_q[FL_OVR];
  assign accept  = frm_valid && !frm_brk && !blocked;
  assign push    = accept && !full;

  always_comb begin
    set_v         = '0;
    set_v[FL_DR]  = push;
    set_v[FL_FER] = frm_valid && frm_fer;
    set_v[FL_PER] = frm_valid && frm_per;
    set_v[FL_BRK] = frm_valid && frm_brk;
    set_v[FL_OVR] = accept && full;
    clr_v = clr ? (clr_mask & arm_q) : '0;
    flg_n = (flg_q & ~clr_v) | set_v;
    arm_n = clr ? (arm_q & ~clr_mask) : arm_q;
    if (sts_rd) arm_n = flg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      arm_q <= '0;
    end else begin
      flg_q <= flg_n;
      arm_q <= arm_n;
    end
  end

  assign flags   = flg_q;
  assign fill    = int'(count) >= fill_level(fill_sel);
  assign rts     = !rx_en || (flow_en && (int'(count) >= rts_level(rts_sel)));
  assign irq_rx  = rx_ie && (flg_q[FL_DR] || fill);
  assign irq_err = (rx_ie || err_ie) && (flg_q[FL_FER] || flg_q[FL_PER]);
  assign irq_brk = (rx_ie || err_ie) && (flg_q[FL_BRK] || flg_q[FL_OVR]);

endmodule

// File: rtl/uart_rx_fc.sv
module uart_rx_fc
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rxd_i,
  input  logic                       baud_tick_i,
  input  logic                       rx_en_i,
  input  logic                       par_en_i,
  input  logic                       par_odd_i,
  input  logic                       flow_en_i,
  input  logic [2:0]                 rts_sel_i,
  input  logic [1:0]                 fill_sel_i,
  input  logic                       rx_ie_i,
  input  logic                       err_ie_i,
  input  logic                       pop_i,
  output logic [7:0]                 rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  input  logic                       sts_rd_i,
  input  logic                       clr_i,
  input  logic [4:0]                 clr_mask_i,
  output logic [5:0]                 status_o,
  output logic                       rts_o,
  output logic                       irq_rx_o,
  output logic                       irq_err_o,
  output logic                       irq_brk_o
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            frm_valid;
  rx_frame_t       frm;
  logic            fifo_push;
  logic            fifo_full;
  logic [FL_N-1:0] flags;
  logic            fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  uart_rx_deframe #(.OSR(OSR)) deframe_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (rx_en_i),
    .tick      (baud_tick_i),
    .rxd       (rxd_i),
    .par_en    (par_en_i),
    .par_odd   (par_odd_i),
    .frm_valid (frm_valid),
    .frm       (frm)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .W(8)) fifo_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (fifo_push),
    .wdata (frm.data),
    .pop   (pop_i),
    .rdata (rdata_o),
    .count (count_o),
    .full  (fifo_full)
  );

  uart_rx_ctl #(.CNT_W(CNT_W)) ctl_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .frm_valid (frm_valid),
    .frm_fer   (frm.fer),
    .frm_per   (frm.per),
    .frm_brk   (frm.brk),
    .count     (count_o),
    .full      (fifo_full),
    .rx_en     (rx_en_i),
    .flow_en   (flow_en_i),
    .rts_sel   (rts_sel_i),
    .fill_sel  (fill_sel_i),
    .rx_ie     (rx_ie_i),
    .err_ie    (err_ie_i),
    .sts_rd    (sts_rd_i),
    .clr       (clr_i),
    .clr_mask  (clr_mask_i),
    .push      (fifo_push),
    .flags     (flags),
    .fill      (fill),
    .rts       (rts_o),
    .irq_rx    (irq_rx_o),
    .irq_err   (irq_err_o),
    .irq_brk   (irq_brk_o)
  );

  assign status_o = {fill, flags};

endmodule

// File: rtl/uart_rx_fc_chk.sv
module uart_rx_fc_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_en_i,
  input logic                       rx_ie_i,
  input logic                       err_ie_i,
  input logic                       pop_i,
  input logic [$clog2(DEPTH+1)-1:0] count_o,
  input logic [5:0]                 status_o,
  input logic                       rts_o,
  input logic                       irq_err_o,
  input logic                       irq_brk_o,
  input logic                       fifo_push
);

  // R11
  rts_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |-> rts_o);

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_o) <= DEPTH);

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count_o) == DEPTH && !pop_i) |=> int'(count_o) == DEPTH);

  // R5
  brk_blocks_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3] || status_o[4]) |-> !fifo_push);

  // R1
  push_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |=> status_o[0]);

  // R7
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0 && pop_i && !fifo_push) |=> count_o == '0);

  // R9
  irq_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err_o |-> ((rx_ie_i || err_ie_i) && (status_o[1] || status_o[2])));

  // R9
  irq_brk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_brk_o |-> ((rx_ie_i || err_ie_i) && (status_o[3] || status_o[4])));

endmodule

bind uart_rx_fc uart_rx_fc_chk #(.DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en_i   (rx_en_i),
  .rx_ie_i   (rx_ie_i),
  .err_ie_i  (err_ie_i),
  .pop_i     (pop_i),
  .count_o   (count_o),
  .status_o  (status_o),
  .rts_o     (rts_o),
  .irq_err_o (irq_err_o),
  .irq_brk_o (irq_brk_o),
  .fifo_push (fifo_push)
);

// File: tb/uart_rx_fc_tb_top.sv
`timescale 1ns/1ps
module uart_rx_fc_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rxd_i;
  logic       baud_tick_i;
  logic       rx_en_i, par_en_i, par_odd_i, flow_en_i;
  logic [2:0] rts_sel_i;
  logic [1:0] fill_sel_i;
  logic       rx_ie_i, err_ie_i, pop_i;
  logic [7:0] rdata_o;
  logic [4:0] count_o;
  logic       sts_rd_i, clr_i;
  logic [4:0] clr_mask_i;
  logic [5:0] status_o;
  logic       rts_o, irq_rx_o, irq_err_o, irq_brk_o;

  int n_chk  = 0;
  int n_fail = 0;
  int tdiv   = 1;
  int tcnt   = 0;

  always #5 clk = ~clk;

  always @(negedge clk) tcnt <= (tcnt >= tdiv - 1) ? 0 : tcnt + 1;
  assign baud_tick_i = (tcnt == 0);

  uart_rx_fc dut_i (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd_i), .baud_tick_i(baud_tick_i),
    .rx_en_i(rx_en_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .flow_en_i(flow_en_i), .rts_sel_i(rts_sel_i), .fill_sel_i(fill_sel_i),
    .rx_ie_i(rx_ie_i), .err_ie_i(err_ie_i), .pop_i(pop_i), .rdata_o(rdata_o),
    .count_o(count_o), .sts_rd_i(sts_rd_i), .clr_i(clr_i),
    .clr_mask_i(clr_mask_i), .status_o(status_o), .rts_o(rts_o),
    .irq_rx_o(irq_rx_o), .irq_err_o(irq_err_o), .irq_brk_o(irq_brk_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rxd_i = b;
    repeat (16 * tdiv) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic with_par,
                            input logic pbit, input logic stopb);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (with_par) send_bit(pbit);
    send_bit(stopb);
    rxd_i = 1'b1;
    repeat (16 * tdiv + 4) @(negedge clk);
  endtask

  task automatic pop_one();
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 20; i++) if (count_o != 0) pop_one();
  endtask

  task automatic clear_flags(input logic [4:0] m);
    sts_rd_i = 1'b1;
    @(negedge clk);
    sts_rd_i = 1'b0;
    clr_i = 1'b1;
    clr_mask_i = m;
    @(negedge clk);
    clr_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 reset count", count_o, 0);
    chk("R11 reset status", status_o, 0);
    chk("R11 rts while disabled", rts_o, 1);
    chk("R9 reset irqs", {irq_rx_o, irq_err_o, irq_brk_o}, 0);
  endtask

  task automatic t_basic();
    send_frame(8'hA5, 1'b0, 1'b0, 1'b1);
    send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
    chk("R1 count after two frames", count_o, 2);
    chk("R1 first byte", rdata_o, 8'hA5);
    chk("R1 data-ready", status_o[0], 1);
    rx_ie_i = 1'b1; @(negedge clk);
    chk("R8 irq_rx on data-ready", irq_rx_o, 1);
    rx_ie_i = 1'b0; @(negedge clk);
    chk("R8 irq_rx masked", irq_rx_o, 0);
    pop_one();
    chk("R7 second byte", rdata_o, 8'h3C);
    chk("R7 count after pop", count_o, 1);
    pop_one();
    pop_one();
    chk("R7 pop on empty", count_o, 0);
    clear_flags(5'h1f);
    chk("R12 cleared after read", status_o, 0);
  endtask

  task automatic t_glitch();
    rxd_i = 1'b0; wait_cyc(4);
    rxd_i = 1'b1; wait_cyc(250);
    chk("R2 short low ignored", count_o, 0);
    chk("R2 no data-ready", status_o[0], 0);
  endtask

  task automatic t_parity();
    par_en_i = 1'b1; par_odd_i = 1'b0; err_ie_i = 1'b1;
    send_frame(8'h5A, 1'b1, 1'b0, 1'b1);
    chk("R3 even parity good", status_o[2], 0);
    send_frame(8'h5B, 1'b1, 1'b0, 1'b1);
    chk("R3 even parity bad flag", status_o[2], 1);
    chk("R3 bad parity byte kept", count_o, 2);
    chk("R9 irq_err on parity", irq_err_o, 1);
    clear_flags(5'h1f);
    chk("R9 irq_err after clear", irq_err_o, 0);
    par_odd_i = 1'b1;
    send_frame(8'h5A, 1'b1, 1'b1, 1'b1);
    chk("R3 odd parity good", status_o[2], 0);
    pop_one();
    chk("R3 stored order", rdata_o, 8'h5B);
    drain(); clear_flags(5'h1f);
    par_en_i = 1'b0; par_odd_i = 1'b0; err_ie_i = 1'b0;
  endtask

  task automatic t_framing();
    send_frame(8'h11, 1'b0, 1'b0, 1'b0);
    chk("R4 framing flag", status_o[1], 1);
    chk("R4 framing byte kept", count_o, 1);
    send_frame(8'h22, 1'b0, 1'b0, 1'b1);
    chk("R4 next frame received", count_o, 2);
    chk("R4 first stored", rdata_o, 8'h11);
    pop_one();
    chk("R4 second stored", rdata_o, 8'h22);
    drain(); clear_flags(5'h1f);
  endtask

  task automatic t_break();
    err_ie_i = 1'b1;
    send_frame(8'h00, 1'b0, 1'b0, 1'b0);
    chk("R5 break flag", status_o[3], 1);
    chk("R5 break not stored", count_o, 0);
    chk("R9 irq_brk on break", irq_brk_o, 1);
    send_frame(8'h77, 1'b0, 1'b0, 1'b1);
    chk("R5 blocked while break set", count_o, 0);
    clear_flags(5'h1f);
    send_frame(8'h77, 1'b0, 1'b0, 1'b1);
    chk("R5 stored after clear", count_o, 1);
    chk("R5 byte value", rdata_o, 8'h77);
    drain(); clear_flags(5'h1f);
    err_ie_i = 1'b0;
  endtask

  task automatic t_overrun();
    int bad = 0;
    err_ie_i = 1'b1;
    for (int i = 0; i < 16; i++) send_frame(8'(i * 7 + 3), 1'b0, 1'b0, 1'b1);
    chk("R6 full count", count_o, 16);
    send_frame(8'hEE, 1'b0, 1'b0, 1'b1);
    chk("R6 overrun flag", status_o[4], 1);
    chk("R6 count unchanged", count_o, 16);
    chk("R9 irq_brk on overrun", irq_brk_o, 1);
    for (int i = 0; i < 16; i++) begin
      if (rdata_o != 8'(i * 7 + 3)) bad++;
      pop_one();
    end
    chk("R6 entries intact in order", bad, 0);
    clear_flags(5'h1f);
    err_ie_i = 1'b0;
  endtask

  task automatic t_rts_fill();
    flow_en_i = 1'b1; rts_sel_i = 3'd2; fill_sel_i = 2'd1;
    for (int i = 0; i < 3; i++) send_frame(8'h40 + 8'(i), 1'b0, 1'b0, 1'b1);
    chk("R10 rts below level 4", rts_o, 0);
    chk("R8 fill below level 4", status_o[5], 0);
    send_frame(8'h43, 1'b0, 1'b0, 1'b1);
    chk("R10 rts at level 4", rts_o, 1);
    chk("R8 fill at level 4", status_o[5], 1);
    clear_flags(5'h01);
    rx_ie_i = 1'b1; @(negedge clk);
    chk("R8 irq_rx from fill", irq_rx_o, 1);
    rts_sel_i = 3'd1; @(negedge clk);
    chk("R10 code1 level 1", rts_o, 1);
    rts_sel_i = 3'd7; @(negedge clk);
    chk("R10 code7 level 14", rts_o, 0);
    rts_sel_i = 3'd0; @(negedge clk);
    chk("R10 code0 level 15", rts_o, 0);
    rts_sel_i = 3'd1; flow_en_i = 1'b0; @(negedge clk);
    chk("R10 flow disabled", rts_o, 0);
    rx_en_i = 1'b0; @(negedge clk);
    chk("R11 rts forced when disabled", rts_o, 1);
    rx_en_i = 1'b1;
    pop_one();
    chk("R8 fill below after pop", status_o[5], 0);
    chk("R8 irq_rx off", irq_rx_o, 0);
    rx_ie_i = 1'b0; fill_sel_i = 2'd0;
  endtask

  task automatic t_disabled();
    rx_en_i = 1'b0;
    send_frame(8'h55, 1'b0, 1'b0, 1'b1);
    chk("R11 no reception when disabled", count_o, 3);
    rx_en_i = 1'b1; wait_cyc(40);
    drain(); clear_flags(5'h1f);
  endtask

  task automatic t_slow_tick();
    tdiv = 4; wait_cyc(40);
    send_frame(8'hC3, 1'b0, 1'b0, 1'b1);
    chk("R13 slow tick count", count_o, 1);
    chk("R13 slow tick byte", rdata_o, 8'hC3);
    tdiv = 1; wait_cyc(40);
    drain(); clear_flags(5'h1f);
  endtask

  task automatic t_clear();
    send_frame(8'h09, 1'b0, 1'b0, 1'b1);
    clr_i = 1'b1; clr_mask_i = 5'h01; @(negedge clk);
    clr_i = 1'b0; @(negedge clk);
    chk("R12 clear without read ignored", status_o[0], 1);
    pop_one();
    clear_flags(5'h01);
    chk("R12 clear after read", status_o[0], 0);
    sts_rd_i = 1'b1; @(negedge clk); sts_rd_i = 1'b0;
    send_frame(8'h0A, 1'b0, 1'b0, 1'b1);
    clr_i = 1'b1; clr_mask_i = 5'h01; @(negedge clk);
    clr_i = 1'b0; @(negedge clk);
    chk("R12 flag set after read kept", status_o[0], 1);
  endtask

  initial begin
    rst_n = 1'b0; rxd_i = 1'b1;
    rx_en_i = 1'b0; par_en_i = 1'b0; par_odd_i = 1'b0; flow_en_i = 1'b0;
    rts_sel_i = 3'd0; fill_sel_i = 2'd0; rx_ie_i = 1'b0; err_ie_i = 1'b0;
    pop_i = 1'b0; sts_rd_i = 1'b0; clr_i = 1'b0; clr_mask_i = 5'h0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    rx_en_i = 1'b1;
    wait_cyc(40);
    t_basic();
    t_glitch();
    t_parity();
    t_framing();
    t_break();
    t_overrun();
    t_rts_fill();
    t_disabled();
    t_slow_tick();
    t_clear();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule